// File: doc/BRIEF.md
# Programmable master-mode sync timing generator

This block produces the horizontal and vertical/field sync outputs of a standard-definition video encoder running as timing master. It runs on the pixel clock, counts pixels within a line and lines within a frame (both totals are parameters), and drives an active-low HSYNC together with one shared frame-timing output. That output carries either a FIELD level (field-output mode) or an active-low VSYNC pulse (VSYNC-output mode), as a mode pin selects.

A single 8-bit timing register shapes the waveforms. Each field is a 2-bit code, and each code picks a value from a short non-linear table: the HSYNC width, the delay from HSYNC to the frame-timing edge, and the VSYNC width or the field offset. Another field delays the pixel data stream by 0 to 3 extra clocks relative to HSYNC. Such a delay can swap the order of the interleaved chroma samples. The register is reached through a small address/strobe port. A write lands in a host copy at once. The active copy, and the mode pin, are loaded only at the first pixel of the next line, so a pulse in flight always finishes with the width it started with.

Top module: `sync_timing_gen`

## Requirements
- R1: While reset is asserted, hsync_n_o is 1, fv_o is 0, pix_data_o is 0 and reg_rdata_o is 0. After reset the timing register reads 0x00.
- R2: A write with reg_we_i at address REG_ADDR (default 0x08) stores all 8 bits. A read with reg_re_i at that address returns the stored value on reg_rdata_o in the next cycle. Any other read returns 0, and writes to other addresses change nothing.
- R3: hsync_n_o falls exactly once every PIX clocks.
- R4: Register bits [1:0] set the HSYNC low time: code 0 gives 1 clock, 1 gives 4, 2 gives 16 and 3 gives 128.
- R5: With tmode_i = 1 (VSYNC mode), fv_o is an active-low pulse once per frame, on line 1. It falls 0, 4, 8 or 16 clocks after the HSYNC fall for bits [3:2] = 0..3. It stays low 1, 4, 16 or 128 clocks for bits [5:4] = 0..3.
- R6: With tmode_i = 0 (field mode), fv_o rises on line 1 at BASE_OFS + delay clocks after the HSYNC fall, plus HALF_OFS when bit 4 is 1. Here the delay is the bits [3:2] value from R5. It falls on line FIELD2_LINE at the delay value after the HSYNC fall. Exactly FIELD2_LINE-1 HSYNC falls lie between the rise and the fall.
- R7: In field mode, register bit 5 has no effect on fv_o.
- R8: pix_data_o equals pix_data_i delayed by 1+k clocks, where k is register bits [7:6].
- R9: A register write takes effect at the first pixel of the following line. An HSYNC pulse already under way keeps its old width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmode_i | input | 1 | 0 = field output, 1 = VSYNC output; sampled at line start |
| reg_addr_i | input | ADDR_W | Register port address |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, one cycle after the strobe |
| pix_data_i | input | DATA_W | Pixel data in |
| pix_data_o | output | DATA_W | Pixel data delayed by 1+k clocks |
| hsync_n_o | output | 1 | Active-low horizontal sync |
| fv_o | output | 1 | FIELD level or active-low VSYNC |

## Verification
Every output comes from a single register stage fed by the same pixel counter. HSYNC and the frame-timing output therefore share one clock of latency, and each separation is counted in whole clocks between edges seen at falling-clock samples. A new register value is not expected until one full line after the write, so each measurement waits PIX+2 clocks and then waits for a fresh HSYNC fall before it starts counting. Read data is sampled one clock after the strobe. The delayed pixel data is compared against the value driven 1+k samples earlier, well away from a line boundary.

// File: rtl/sync_timing_pkg.sv
package sync_timing_pkg;

    typedef enum logic {
        MODE_FIELD = 1'b0,
        MODE_VSYNC = 1'b1
    } tmode_e;

    // Field layout is fixed: [7:6] data shift, [5:4] vsync width / field offset,
    // [3:2] hsync-to-frame-edge delay, [1:0] hsync width
    typedef struct packed {
        logic [1:0] dsel;
        logic [1:0] vsel;
        logic [1:0] dly;
        logic [1:0] hsel;
    } treg_t;

    function automatic logic [7:0] width_of(input logic [1:0] code);
        case (code)
            2'd0:    width_of = 8'd1;
            2'd1:    width_of = 8'd4;
            2'd2:    width_of = 8'd16;
            default: width_of = 8'd128;
        endcase
    endfunction

    function automatic logic [4:0] delay_of(input logic [1:0] code);
        case (code)
            2'd0:    delay_of = 5'd0;
            2'd1:    delay_of = 5'd4;
            2'd2:    delay_of = 5'd8;
            default: delay_of = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/sync_timing_regs.sv
module sync_timing_regs
    import sync_timing_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              tmode_i,
    input  logic              load_i,
    output treg_t             act_cfg_o,
    output tmode_e            act_mode_o
);

    typedef struct packed {
        treg_t      host;
        treg_t      act;
        tmode_e     mode;
        logic [7:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = (reg_addr_i == ADDR_W'(REG_ADDR));
        if (reg_we_i && hit) begin
            st_d.host = treg_t'(reg_wdata_i);
        end
        st_d.rdata = (reg_re_i && hit) ? 8'(st_q.host) : 8'd0;
        if (load_i) begin
            st_d.act  = st_q.host;
            st_d.mode = tmode_e'(tmode_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{host: '0, act: '0, mode: MODE_FIELD, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o = st_q.rdata;
    assign act_cfg_o   = st_q.act;
    assign act_mode_o  = st_q.mode;

endmodule

// File: rtl/sync_timing_counter.sv
module sync_timing_counter #(
    parameter int PIX    = 1728,
    parameter int LINES  = 625,
    parameter int PIX_W  = $clog2(PIX),
    parameter int LINE_W = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PIX_W-1:0]  pix_o,
    output logic [LINE_W-1:0] line_o,
    output logic              last_pix_o
);

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic last;

    always_comb begin
        cnt_d = cnt_q;
        last  = (cnt_q.pix == PIX_W'(PIX - 1));
        if (last) begin
            cnt_d.pix  = '0;
            cnt_d.line = (cnt_q.line == LINE_W'(LINES)) ? LINE_W'(1) : cnt_q.line + LINE_W'(1);
        end else begin
            cnt_d.pix = cnt_q.pix + PIX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '{pix: '0, line: LINE_W'(1)};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pix_o      = cnt_q.pix;
    assign line_o     = cnt_q.line;
    assign last_pix_o = last;

endmodule

// File: rtl/sync_timing_pulse.sv
module sync_timing_pulse
    import sync_timing_pkg::*;
#(
    parameter int PIX_W       = 11,
    parameter int LINE_W      = 10,
    parameter int FIELD2_LINE = 313,
    parameter int BASE_OFS    = 0,
    parameter int HALF_OFS    = 864
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [1:0]        hsel_i,
    input  logic [1:0]        dly_i,
    input  logic [1:0]        vsel_i,
    input  tmode_e            mode_i,
    output logic              hsync_n_o,
    output logic              fv_o
);

    typedef struct packed {
        logic hs_n;
        logic fv;
    } pulse_t;

    pulse_t pl_d, pl_q;
    logic [31:0] p, hsw, vsw, dly, rise;
    logic        on_first, on_second;

    always_comb begin
        pl_d      = pl_q;
        p         = 32'(pix_i);
        hsw       = 32'(width_of(hsel_i));
        vsw       = 32'(width_of(vsel_i));
        dly       = 32'(delay_of(dly_i));
        rise      = 32'(BASE_OFS) + dly + (vsel_i[0] ? 32'(HALF_OFS) : 32'd0);
        on_first  = (32'(line_i) == 32'd1);
        on_second = (32'(line_i) == 32'(FIELD2_LINE));

        pl_d.hs_n = !(p < hsw);

        if (mode_i == MODE_VSYNC) begin
            pl_d.fv = !(on_first && (p >= dly) && (p < dly + vsw));
        end else begin
            if (on_first && (p == rise)) begin
                pl_d.fv = 1'b1;
            end
            if (on_second && (p == dly)) begin
                pl_d.fv = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_q <= '{hs_n: 1'b1, fv: 1'b0};
        end else begin
            pl_q <= pl_d;
        end
    end

    assign hsync_n_o = pl_q.hs_n;
    assign fv_o      = pl_q.fv;

endmodule

// File: rtl/sync_timing_data_dly.sv
module sync_timing_data_dly #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 3,
    parameter int SEL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] stg;
        logic [DATA_W-1:0]            dout;
    } dly_t;

    dly_t dl_d, dl_q;

    always_comb begin
        dl_d        = dl_q;
        dl_d.stg[0] = din_i;
        for (int i = 1; i < DEPTH; i++) begin
            dl_d.stg[i] = dl_q.stg[i-1];
        end
        if (sel_i == '0) begin
            dl_d.dout = din_i;
        end else begin
            dl_d.dout = dl_q.stg[sel_i - SEL_W'(1)];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
        end else begin
            dl_q <= dl_d;
        end
    end

    assign dout_o = dl_q.dout;

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
    import sync_timing_pkg::*;
#(
    parameter int PIX         = 1728,
    parameter int LINES       = 625,
    parameter int FIELD2_LINE = 313,
    parameter int BASE_OFS    = 0,
    parameter int HALF_OFS    = 864,
    parameter int DATA_W      = 10,
    parameter int ADDR_W      = 8,
    parameter int REG_ADDR    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmode_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic [DATA_W-1:0] pix_data_o,
    output logic              hsync_n_o,
    output logic              fv_o
);

    localparam int PIX_W  = $clog2(PIX);
    localparam int LINE_W = $clog2(LINES + 1);

    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              last_pix;
    treg_t             act_cfg;
    tmode_e            act_mode;

    sync_timing_counter #(
        .PIX(PIX), .LINES(LINES), .PIX_W(PIX_W), .LINE_W(LINE_W)
    ) u_counter (
        .clk(clk), .rst_n(rst_n),
        .pix_o(pix_cnt), .line_o(line_cnt), .last_pix_o(last_pix)
    );

    sync_timing_regs #(
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .tmode_i(tmode_i), .load_i(last_pix),
        .act_cfg_o(act_cfg), .act_mode_o(act_mode)
    );

    sync_timing_pulse #(
        .PIX_W(PIX_W), .LINE_W(LINE_W), .FIELD2_LINE(FIELD2_LINE),
        .BASE_OFS(BASE_OFS), .HALF_OFS(HALF_OFS)
    ) u_pulse (
        .clk(clk), .rst_n(rst_n),
        .pix_i(pix_cnt), .line_i(line_cnt),
        .hsel_i(act_cfg.hsel), .dly_i(act_cfg.dly), .vsel_i(act_cfg.vsel),
        .mode_i(act_mode),
        .hsync_n_o(hsync_n_o), .fv_o(fv_o)
    );

    sync_timing_data_dly #(
        .DATA_W(DATA_W), .DEPTH(3), .SEL_W(2)
    ) u_data (
        .clk(clk), .rst_n(rst_n),
        .sel_i(act_cfg.dsel), .din_i(pix_data_i), .dout_o(pix_data_o)
    );

endmodule

// File: rtl/sync_timing_chk.sv
module sync_timing_chk #(
    parameter int PIX         = 1728,
    parameter int FIELD2_LINE = 313,
    parameter int PIX_W       = 11,
    parameter int LINE_W      = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_n,
    input logic              fv,
    input logic              reg_re,
    input logic [7:0]        rdata,
    input logic [PIX_W-1:0]  pix,
    input logic [LINE_W-1:0] line,
    input logic [7:0]        act_cfg,
    input logic              act_mode
);

    logic [1:0]        cyc;
    logic              hs_prev, fv_prev, seen, mode_p1, mode_p2;
    logic [31:0]       hs_gap, hs_low;
    logic [8:0]        cfg_prev;
    logic [LINE_W-1:0] line_prev;
    logic              hs_fall;

    assign hs_fall = hs_prev && !hsync_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc       <= '0;
            hs_prev   <= 1'b1;
            fv_prev   <= 1'b0;
            seen      <= 1'b0;
            mode_p1   <= 1'b0;
            mode_p2   <= 1'b0;
            hs_gap    <= '0;
            hs_low    <= '0;
            cfg_prev  <= '0;
            line_prev <= LINE_W'(1);
        end else begin
            cyc       <= (cyc == 2'd3) ? cyc : cyc + 2'd1;
            hs_prev   <= hsync_n;
            fv_prev   <= fv;
            mode_p1   <= act_mode;
            mode_p2   <= mode_p1;
            cfg_prev  <= {act_cfg, act_mode};
            line_prev <= line;
            hs_low    <= hsync_n ? 32'd0 : hs_low + 32'd1;
            if (hs_fall) begin
                seen   <= 1'b1;
                hs_gap <= 32'd1;
            end else begin
                hs_gap <= hs_gap + 32'd1;
            end
        end
    end

    // R3
    a_r3_hs_period: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_fall && seen) |-> (hs_gap == 32'(PIX)));

    // R4
    a_r4_hs_width_max: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> (hs_low < 32'd128));

    // R9
    a_r9_cfg_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        ({act_cfg, act_mode} != cfg_prev) |-> (pix == '0));

    // R2
    a_r2_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> (rdata == 8'd0));

    // R6
    a_r6_field_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc == 2'd3) && !mode_p1 && !mode_p2 && (fv != fv_prev))
        |-> ((line_prev == LINE_W'(1)) || (line_prev == LINE_W'(FIELD2_LINE))));

endmodule

bind sync_timing_gen sync_timing_chk #(
    .PIX(PIX), .FIELD2_LINE(FIELD2_LINE), .PIX_W(PIX_W), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n_o), .fv(fv_o),
    .reg_re(reg_re_i), .rdata(reg_rdata_o), .pix(pix_cnt), .line(line_cnt),
    .act_cfg(act_cfg), .act_mode(act_mode)
);

// File: tb/sync_timing_gen_bench.sv
module sync_timing_gen_bench;

    localparam int PIX    = 400;
    localparam int LINES  = 8;
    localparam int F2     = 5;
    localparam int BASE   = 8;
    localparam int HALF   = 160;
    localparam int DW     = 10;
    localparam int FRAME  = PIX * LINES;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmode_i = 1'b0;
    logic [7:0]    reg_addr_i = '0;
    logic          reg_we_i = 1'b0;
    logic          reg_re_i = 1'b0;
    logic [7:0]    reg_wdata_i = '0;
    logic [7:0]    reg_rdata_o;
    logic [DW-1:0] pix_data_i = '0;
    logic [DW-1:0] pix_data_o;
    logic          hsync_n_o, fv_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sync_timing_gen #(
        .PIX(PIX), .LINES(LINES), .FIELD2_LINE(F2), .BASE_OFS(BASE),
        .HALF_OFS(HALF), .DATA_W(DW), .ADDR_W(8), .REG_ADDR(8)
    ) u_sync_timing_gen (
        .clk(clk), .rst_n(rst_n), .tmode_i(tmode_i),
        .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .pix_data_i(pix_data_i), .pix_data_o(pix_data_o),
        .hsync_n_o(hsync_n_o), .fv_o(fv_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_w(input logic [1:0] c);
        case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 16; default: return 128; endcase
    endfunction

    function automatic int exp_d(input logic [1:0] c);
        case (c) 2'd0: return 0; 2'd1: return 4; 2'd2: return 8; default: return 16; endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_re_i = 1'b1;
        @(negedge clk);
        reg_re_i = 1'b0;
        d = reg_rdata_o;
    endtask

    task automatic wait_load();
        repeat (PIX + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        repeat (5) @(negedge clk);
        check(hsync_n_o == 1'b1, "R1 hsync_n in reset", int'(hsync_n_o), 1);
        check(fv_o == 1'b0, "R1 fv in reset", int'(fv_o), 0);
        check(pix_data_o == '0, "R1 data in reset", int'(pix_data_o), 0);
        check(reg_rdata_o == 8'd0, "R1 rdata in reset", int'(reg_rdata_o), 0);
        rst_n = 1'b1;
        rd(8'h08, d);
        check(d == 8'h00, "R1 register after reset", int'(d), 0);
    endtask

    task automatic t_regport();
        logic [7:0] d;
        wr(8'h08, 8'hA5);
        rd(8'h08, d);
        check(d == 8'hA5, "R2 readback", int'(d), 'hA5);
        wr(8'h09, 8'h3C);
        rd(8'h08, d);
        check(d == 8'hA5, "R2 foreign write ignored", int'(d), 'hA5);
        rd(8'h09, d);
        check(d == 8'h00, "R2 foreign read zero", int'(d), 0);
    endtask

    task automatic t_shadow();
        int n;
        logic hp;
        tmode_i = 1'b0;
        wr(8'h08, 8'h03);
        wait_load();
        hp = hsync_n_o;
        forever begin
            @(negedge clk);
            if (hp && !hsync_n_o) break;
            hp = hsync_n_o;
        end
        n = 1;
        wr(8'h08, 8'h00);
        n += 2;
        forever begin
            @(negedge clk);
            if (hsync_n_o) break;
            n++;
        end
        check(n == 128, "R9 pulse in flight keeps width", n, 128);
        hp = hsync_n_o;
        forever begin
            @(negedge clk);
            if (hp && !hsync_n_o) break;
            hp = hsync_n_o;
        end
        n = 1;
        forever begin
            @(negedge clk);
            if (hsync_n_o) break;
            n++;
        end
        check(n == 1, "R9 new width on next line", n, 1);
    endtask

    task automatic t_vsync(input logic [1:0] c);
        int since, hsr, hsw, vsep, vw, vrun, per;
        logic hp, fp, hs, fv, armed, fell;
        @(negedge clk);
        tmode_i = 1'b1;
        wr(8'h08, {c, c, c, c});
        wait_load();
        hp = hsync_n_o; fp = fv_o; armed = 0; fell = 0;
        since = 0; hsr = 0; hsw = -1; vsep = -1; vw = -1; vrun = 0; per = -1;
        for (int i = 0; i < 3 * FRAME && vw < 0; i++) begin
            @(negedge clk);
            hs = hsync_n_o; fv = fv_o;
            if (hp && !hs) begin
                if (armed && per < 0) per = since + 1;
                armed = 1; since = 0; hsr = 1;
            end else begin
                since++;
                if (!hs) hsr++;
                else if (!hp && armed && hsw < 0) hsw = hsr;
            end
            if (armed && fp && !fv) begin
                fell = 1; vsep = since; vrun = 1;
            end else if (fell && !fv) begin
                vrun++;
            end else if (fell && !fp && fv) begin
                vw = vrun;
            end
            hp = hs; fp = fv;
        end
        check(per == PIX, "R3 hsync period", per, PIX);
        check(hsw == exp_w(c), "R4 hsync width", hsw, exp_w(c));
        check(vsep == exp_d(c), "R5 vsync delay", vsep, exp_d(c));
        check(vw == exp_w(c), "R5 vsync width", vw, exp_w(c));
    endtask

    task automatic t_field(input logic [1:0] dc, input logic b4, input logic b5);
        int since, rsep, fsep, hcnt, exp_r;
        logic hp, fp, hs, fv, armed, rose, done;
        @(negedge clk);
        tmode_i = 1'b0;
        wr(8'h08, {2'b00, b5, b4, dc, 2'b01});
        wait_load();
        hp = hsync_n_o; fp = fv_o; armed = 0; rose = 0; done = 0;
        since = 0; rsep = -1; fsep = -1; hcnt = -1;
        for (int i = 0; i < 3 * FRAME && !done; i++) begin
            @(negedge clk);
            hs = hsync_n_o; fv = fv_o;
            if (hp && !hs) begin
                armed = 1; since = 0;
                if (rose) hcnt++;
            end else begin
                since++;
            end
            if (armed && !fp && fv && !rose) begin
                rose = 1; rsep = since; hcnt = 0;
            end else if (rose && fp && !fv) begin
                fsep = since; done = 1;
            end
            hp = hs; fp = fv;
        end
        exp_r = BASE + exp_d(dc) + (b4 ? HALF : 0);
        check(rsep == exp_r, b5 ? "R7 R6 field rise offset (bit5 set)" : "R6 field rise offset", rsep, exp_r);
        check(fsep == exp_d(dc), "R6 field fall offset", fsep, exp_d(dc));
        check(hcnt == F2 - 1, "R6 lines in first field", hcnt, F2 - 1);
    endtask

    task automatic t_data(input logic [1:0] k);
        logic [DW-1:0] hist [4];
        logic [DW-1:0] got;
        wr(8'h08, {k, 6'b000001});
        wait_load();
        for (int j = 0; j < 4; j++) hist[j] = '0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            got = pix_data_o;
            if (i >= 5) check(got == hist[k], "R8 data latency", int'(got), int'(hist[k]));
            for (int j = 3; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = DW'(i * 37 + 5 + int'(k) * 101);
            pix_data_i = hist[0];
        end
    endtask

    initial begin
        t_reset();
        t_regport();
        t_shadow();
        for (int c = 0; c < 4; c++) t_vsync(2'(c));
        for (int k = 0; k < 4; k++) t_data(2'(k));
        for (int d = 0; d < 4; d++) begin
            t_field(2'(d), 1'b0, d[0]);
            t_field(2'(d), 1'b1, ~d[0]);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule